// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits between a requester and a single DRAM bank. It takes one read or write request at a time and turns it into the ordered steps the bank needs: open a row, make a column access, and close the row with a precharge when a different row is wanted. Row and column share one address bus, so the row goes out with the activate step and the column goes out later with the access step.

The last activated row is kept open after the access. A later request to the same row goes straight to a column access, even after idle cycles. A request to another row first precharges the open one and then activates the new one. The minimum spacing after each kind of step is a parameter counted in clock cycles, and no command leaves before that spacing has run out. Read data comes back to the requester as a one-cycle valid pulse, in the order the reads were accepted.

Top module: `bank_cmd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `dram_cmd` is NOP, `dram_addr` and `dram_wdata` are zero, `rsp_valid` is low, `req_ready` is high and no row counts as open.
- R2: Command codes on `dram_cmd` are NOP=0, ACT=1, RD=2, WR=3, PRE=4. The request address holds the row in its upper ROW_W bits and the column in its lower COL_W bits. `dram_addr` carries the row, zero-extended, with ACT, carries the column, zero-extended, with RD and WR, and is zero otherwise.
- R3: A request that finds no row open produces ACT for its row, followed by RD or WR.
- R4: A request to the row already open produces RD or WR with no ACT and no PRE before it.
- R5: A request to a row other than the open one produces PRE, then ACT for the new row, then RD or WR.
- R6: The cycle distance from a command to the next non-NOP command is at least T_ACT after ACT, T_COL after RD or WR, and T_PRE after PRE. A held request issues its next command in the first cycle that spacing allows, one cycle after acceptance at the earliest.
- R7: `req_ready` is low from the cycle after a request is accepted until the cycle after its RD or WR command. Request inputs while `req_ready` is low have no effect.
- R8: Each RD command gives exactly one `rsp_valid` pulse. The pulse is one cycle long and comes two cycles after the RD cycle.
- R9: In the WR cycle `dram_wdata` holds the request's write data, and it is zero in all other cycles. `rsp_rdata` holds the bank word sampled the cycle after RD, so a read returns the data last written to that row and column.
- R10: An open row stays open through idle cycles. It is precharged only when a request for a different row arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row (upper bits) and column (lower bits) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| dram_cmd | output | 3 | Bank command code |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| dram_wdata | output | DATA_W | Data for the WR command |
| dram_rdata | input | DATA_W | Bank data, valid the cycle after RD |

## Verification
The assertions assume the bank answers RD with its data in the next cycle, and that the requester keeps each request's fields steady in the cycle it is accepted. The bench's bank model registers its read word on the RD edge. The stimulus changes fields only at the falling edge, after `req_ready` has settled. While `req_ready` is low, the bench drives scrambled write data to show that stalled inputs are ignored. Row addresses are drawn from a small set so that hits, misses and closed-row cases all occur, both back-to-back and with idle gaps.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } bank_cmd_e;

  function automatic logic is_column(bank_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/bank_step_timer.sv
module bank_step_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired = (remain_q == '0);

  // R6: a step is launched only after the previous wait has run out
  a_r6_load_when_expired: assert property (@(posedge clk) disable iff (rst)
    load |-> expired);

endmodule

// File: rtl/bank_open_row.sv
module bank_open_row #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             activate,
  input  logic             close,
  input  logic [ROW_W-1:0] act_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             is_open,
  output logic             hit
);

  logic [ROW_W-1:0] row_q;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (activate) begin
      open_q <= 1'b1;
      row_q  <= act_row;
    end else if (close) begin
      open_q <= 1'b0;
    end
  end

  assign is_open = open_q;
  assign hit     = open_q && (row_q == cmp_row);

  // R3: activation only on a closed bank
  a_r3_act_when_closed: assert property (@(posedge clk) disable iff (rst)
    activate |-> !open_q);
  // R5: precharge only when a row is open
  a_r5_close_when_open: assert property (@(posedge clk) disable iff (rst)
    close |-> open_q);
  // R10: the open flag drops only through a precharge
  a_r10_stays_open: assert property (@(posedge clk) disable iff (rst)
    (open_q && !close) |=> open_q);

endmodule

// File: rtl/bank_read_return.sv
module bank_read_return #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_seen,
  input  logic [DATA_W-1:0] bank_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      wait_q    <= rd_seen;
      rsp_valid <= wait_q;
      if (wait_q) rsp_rdata <= bank_data;
    end
  end

  // R8: every strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int T_ACT  = 3,
  parameter int T_COL  = 2,
  parameter int T_PRE  = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [2:0]             dram_cmd,
  output logic [ADDR_W-1:0]      dram_addr,
  output logic [DATA_W-1:0]      dram_wdata,
  input  logic [DATA_W-1:0]      dram_rdata
);

  localparam int T_MAX1 = (T_ACT > T_COL) ? T_ACT : T_COL;
  localparam int T_MAX  = (T_MAX1 > T_PRE) ? T_MAX1 : T_PRE;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] WAIT_ACT = CNT_W'(T_ACT - 1);
  localparam logic [CNT_W-1:0] WAIT_COL = CNT_W'(T_COL - 1);
  localparam logic [CNT_W-1:0] WAIT_PRE = CNT_W'(T_PRE - 1);

  // held request
  logic              held_q;
  logic              held_wr_q;
  logic [ROW_W-1:0]  held_row_q;
  logic [COL_W-1:0]  held_col_q;
  logic [DATA_W-1:0] held_data_q;

  // registered command outputs
  bank_cmd_e         cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic step_ok, row_open, row_hit;
  logic go, go_col, go_pre, go_act;
  logic accept;
  logic [CNT_W-1:0] wait_val;

  assign req_ready = !held_q;
  assign accept    = req_valid && req_ready;

  assign go     = held_q && step_ok;
  assign go_col = go && row_hit;
  assign go_pre = go && row_open && !row_hit;
  assign go_act = go && !row_open;

  always_comb begin
    wait_val = WAIT_PRE;
    if (go_act) wait_val = WAIT_ACT;
    else if (go_col) wait_val = WAIT_COL;
  end

  bank_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .load_val (wait_val),
    .expired  (step_ok)
  );

  bank_open_row #(.ROW_W(ROW_W)) u_row (
    .clk      (clk),
    .rst      (rst),
    .activate (go_act),
    .close    (go_pre),
    .act_row  (held_row_q),
    .cmp_row  (held_row_q),
    .is_open  (row_open),
    .hit      (row_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q      <= 1'b0;
      held_wr_q   <= 1'b0;
      held_row_q  <= '0;
      held_col_q  <= '0;
      held_data_q <= '0;
      cmd_q       <= CMD_NOP;
      addr_q      <= '0;
      wdata_q     <= '0;
    end else begin
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      wdata_q <= '0;
      if (go_act) begin
        cmd_q  <= CMD_ACT;
        addr_q <= ADDR_W'(held_row_q);
      end else if (go_pre) begin
        cmd_q <= CMD_PRE;
      end else if (go_col) begin
        cmd_q  <= held_wr_q ? CMD_WR : CMD_RD;
        addr_q <= ADDR_W'(held_col_q);
        if (held_wr_q) wdata_q <= held_data_q;
        held_q <= 1'b0;
      end
      if (accept) begin
        held_q      <= 1'b1;
        held_wr_q   <= req_write;
        held_row_q  <= req_addr[ROW_W+COL_W-1:COL_W];
        held_col_q  <= req_addr[COL_W-1:0];
        held_data_q <= req_wdata;
      end
    end
  end

  assign dram_cmd   = cmd_q;
  assign dram_addr  = addr_q;
  assign dram_wdata = wdata_q;

  bank_read_return #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .rd_seen   (cmd_q == CMD_RD),
    .bank_data (dram_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // ---------------- checks on command spacing ----------------
  localparam int GAP_W = CNT_W + 1;
  logic [GAP_W-1:0] gap_q;
  bank_cmd_e        last_q;
  logic             seen_q;
  int               need_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      last_q <= CMD_NOP;
      seen_q <= 1'b0;
    end else if (cmd_q != CMD_NOP) begin
      gap_q  <= GAP_W'(1);
      last_q <= cmd_q;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_comb begin
    case (last_q)
      CMD_ACT: need_gap = T_ACT;
      CMD_PRE: need_gap = T_PRE;
      default: need_gap = T_COL;
    endcase
  end

  // R6: minimum distance between consecutive commands
  a_r6_step_spacing: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP && seen_q) |-> (int'(gap_q) >= need_gap));
  // R4: column accesses only into an open row
  a_r4_col_needs_open: assert property (@(posedge clk) disable iff (rst)
    is_column(cmd_q) |-> row_open);
  // R7: an accepted request closes the door next cycle
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  // R8: a strobe traces back to a read two cycles earlier
  a_r8_strobe_follows_rd: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(cmd_q == CMD_RD, 2));

endmodule

// File: tb/tb_bank_cmd_seq.sv
`timescale 1ns/1ps
module tb_bank_cmd_seq;

  localparam int ROW_W = 4, COL_W = 3, DATA_W = 16;
  localparam int T_ACT = 3, T_COL = 2, T_PRE = 4;
  localparam int ADDR_W = 4, COLS = 8, DEPTH = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata, dram_wdata;
  logic [DATA_W-1:0] dram_rdata = '0;
  logic [2:0] dram_cmd;
  logic [ADDR_W-1:0] dram_addr;

  always #2.5 clk = ~clk;

  bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                 .T_ACT(T_ACT), .T_COL(T_COL), .T_PRE(T_PRE)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_cmd(dram_cmd),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata));

  int vec = 0, fails = 0, cyc = 0;
  int act_cnt = 0, pre_cnt = 0, rd_cnt = 0, rsp_cnt = 0;

  // behavioural bank: row latch, array, one-cycle read
  logic [DATA_W-1:0] bank_mem [DEPTH];
  int brow = 0;
  always @(posedge clk) begin
    case (dram_cmd)
      3'd1: brow <= int'(dram_addr);
      3'd2: dram_rdata <= bank_mem[brow*COLS + int'(dram_addr)];
      3'd3: bank_mem[brow*COLS + int'(dram_addr)] <= dram_wdata;
      default: ;
    endcase
  end

  // reference model, advanced on every rising edge
  logic [DATA_W-1:0] shadow [DEPTH];
  bit m_pend, m_pwr, m_open, m_rdpend, m_rsp_v;
  int m_prow, m_pcol, m_orow, m_cnt, m_cmd, m_addr;
  logic [DATA_W-1:0] m_pdata, m_wdata, m_hold, m_rsp_d;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bank_mem[i] = '0;
      shadow[i] = '0;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      m_pend = 0; m_open = 0; m_rdpend = 0; m_rsp_v = 0;
      m_cnt = 0; m_cmd = 0; m_addr = 0; m_wdata = '0; m_rsp_d = '0;
    end else begin
      bit was_pend;
      was_pend = m_pend;
      m_rsp_v = m_rdpend;
      if (m_rdpend) m_rsp_d = m_hold;
      m_rdpend = (m_cmd == 2);
      m_cmd = 0; m_addr = 0; m_wdata = '0;
      if (m_pend && m_cnt == 0) begin
        if (m_open && m_orow == m_prow) begin
          m_cmd = m_pwr ? 3 : 2;
          m_addr = m_pcol;
          m_cnt = T_COL - 1;
          if (m_pwr) begin
            m_wdata = m_pdata;
            shadow[m_prow*COLS + m_pcol] = m_pdata;
          end else begin
            m_hold = shadow[m_prow*COLS + m_pcol];
          end
          m_pend = 0;
        end else if (m_open) begin
          m_cmd = 4; m_cnt = T_PRE - 1; m_open = 0;
        end else begin
          m_cmd = 1; m_addr = m_prow; m_cnt = T_ACT - 1;
          m_open = 1; m_orow = m_prow;
        end
      end else if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
      end
      if (!was_pend && req_valid) begin
        m_pend = 1; m_pwr = req_write;
        m_prow = int'(req_addr[ROW_W+COL_W-1:COL_W]);
        m_pcol = int'(req_addr[COL_W-1:0]);
        m_pdata = req_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(dram_cmd) == m_cmd, "R6 cmd sequence/timing (R3 R4 R5)", int'(dram_cmd), m_cmd);
      chk(int'(dram_addr) == m_addr, "R2 address mux", int'(dram_addr), m_addr);
      chk(dram_wdata == m_wdata, "R9 write data", int'(dram_wdata), int'(m_wdata));
      chk(req_ready == !m_pend, "R7 ready", int'(req_ready), int'(!m_pend));
      chk(rsp_valid == m_rsp_v, "R8 response strobe", int'(rsp_valid), int'(m_rsp_v));
      if (m_rsp_v)
        chk(rsp_rdata == m_rsp_d, "R9 read data", int'(rsp_rdata), int'(m_rsp_d));
      if (dram_cmd == 3'd1) act_cnt++;
      if (dram_cmd == 3'd4) pre_cnt++;
      if (dram_cmd == 3'd2) rd_cnt++;
      if (rsp_valid) rsp_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  end

  // issue one request; stalled cycles carry scrambled data (R7)
  task automatic send(input bit wr, input int row, input int col, input logic [DATA_W-1:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {ROW_W'(row), COL_W'(col)};
    req_wdata = ~d;
    forever begin
      if (req_ready) begin
        req_wdata = d;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    req_wdata = 16'hdead;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int a0, p0, r0, s0;
  logic [15:0] lfsr = 16'hace1;

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs while reset is held
    chk(dram_cmd == 3'd0 && dram_addr == '0 && !rsp_valid && req_ready,
        "R1 reset outputs", int'(dram_cmd), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_cmd == 3'd0 && dram_wdata == '0 && req_ready, "R1 after reset", int'(dram_cmd), 0);

    // R3: closed bank -> ACT then WR
    a0 = act_cnt; p0 = pre_cnt;
    send(1, 2, 1, 16'h1234);
    idle(12);
    chk(act_cnt - a0 == 1, "R3 one activate", act_cnt - a0, 1);
    chk(pre_cnt - p0 == 0, "R3 no precharge", pre_cnt - p0, 0);

    // R4 / R10: same row after idle gap, no ACT or PRE
    a0 = act_cnt; p0 = pre_cnt; s0 = rsp_cnt;
    send(0, 2, 1, 16'h0);
    send(1, 2, 5, 16'hbeef);
    idle(6);
    send(0, 2, 5, 16'h0);
    idle(10);
    chk(act_cnt - a0 == 0, "R4 no activate on hit", act_cnt - a0, 0);
    chk(pre_cnt - p0 == 0, "R10 row kept open", pre_cnt - p0, 0);
    chk(rsp_cnt - s0 == 2, "R8 two reads two strobes", rsp_cnt - s0, 2);

    // R5: row change -> PRE, ACT, RD
    a0 = act_cnt; p0 = pre_cnt;
    send(0, 7, 0, 16'h0);
    idle(16);
    chk(pre_cnt - p0 == 1, "R5 one precharge", pre_cnt - p0, 1);
    chk(act_cnt - a0 == 1, "R5 one activate", act_cnt - a0, 1);

    // mixed traffic, back-to-back and with gaps
    r0 = rd_cnt; s0 = rsp_cnt;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[0], int'(lfsr[3:2]), int'(lfsr[6:4]), lfsr ^ 16'h5a5a);
      if (lfsr[9:8] == 2'b00) idle(int'(lfsr[12:10]));
    end
    idle(20);
    chk(rsp_cnt - s0 == rd_cnt - r0, "R8 strobes match reads", rsp_cnt - s0, rd_cnt - r0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

endmodule